// File: doc/BRIEF.md
# Synchronizing Word Memory

This block is a small memory in which every word carries a 64-bit data value, a one-bit full/empty flag used for synchronization, and a one-bit pointer tag. Besides plain loads and stores it serves conditional accesses. A conditional access names the flag value it expects (the precondition) and the flag value to leave behind (the postcondition). If the word's flag equals the expectation, the access moves its data and rewrites the flag as one indivisible step. If it does not, the word is left untouched. Either way a one-bit success result comes back, so that software can branch on it. Spin locks, producer/consumer hand-offs and atomic read-modify-write sequences are built on this result.

The storage is split into two banks. Bit 0 of the word address selects the bank, so consecutive words sit in alternate banks. One request is accepted per cycle, and its response appears exactly three cycles later. Every response carries the request's tag, so that the success flag can be steered to the condition-code register that asked for it. The banks finish the flag test and the flag update within one cycle. Because of this, a conditional request always sees the outcome of the request issued just before it, even when both use the same address.

Top module: `syncbit_mem`

## Requirements
- R1: While reset is held, `rsp_valid` is 0. After reset every word's synchronization flag and pointer bit are 0, so a conditional access expecting 1 on a word never written fails.
- R2: The operation code is 0 for a load, 1 for a store, 2 for a conditional load and 3 for a conditional store. A plain load returns the word's data and pointer bit with `rsp_ok`=1. A plain store writes data and pointer with `rsp_ok`=1 and returns zero data and pointer 0.
- R3: A conditional load whose precondition equals the word's flag returns the data and pointer with `rsp_ok`=1, and sets the flag to the postcondition.
- R4: A conditional store whose precondition equals the word's flag writes data and pointer, sets the flag to the postcondition, and returns `rsp_ok`=1 with zero data and pointer 0.
- R5: A conditional access whose precondition differs from the flag leaves data, pointer and flag unchanged. It returns `rsp_ok`=0, zero data and pointer 0.
- R6: Each accepted request yields exactly one response, three cycles after the cycle in which `req_valid` was 1. Responses come in request order, one per cycle at full rate. An idle cycle yields no response.
- R7: Plain loads and stores neither read nor change the synchronization flag.
- R8: Back-to-back requests to the same address take effect in issue order, and each one observes the flag and data left by the one before it.
- R9: Address bit 0 selects one of two banks. Words whose addresses differ only in bit 0 are independent: an access to one never alters or reads the other.
- R10: Every response carries the tag of the request it answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (see R2) |
| req_addr | input | ADDR_W | Word address; bit 0 picks the bank |
| req_data | input | DATA_W | Store data |
| req_ptr | input | 1 | Pointer bit to store |
| req_pre | input | 1 | Expected flag value for conditional operations |
| req_post | input | 1 | Flag value written on a successful conditional operation |
| req_tag | input | TAG_W | Destination tag, echoed in the response |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | DATA_W | Load data, zero for stores and failures |
| rsp_ptr | output | 1 | Pointer bit of loaded word |
| rsp_ok | output | 1 | Success flag for the condition-code destination |
| rsp_tag | output | TAG_W | Tag of the answered request |

## Verification
A wrong flag inside a bank does not show up at once. It shows up on the next conditional access to that word, as an inverted `rsp_ok` three cycles after that request. The later data returns may also be zero or stale, so the bench follows every flag change with a conditional probe or a plain load. A slip in the pipeline shows up sooner: a misaligned valid or tag is visible on the very cycle the response is due. Cross-bank corruption is caught by probing the neighbouring word straight after a flag change.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_SLOAD  = 2'd2,
        OP_SSTORE = 2'd3
    } sbm_op_e;

    // action a bank takes for the access it sees this cycle
    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_READ,
        ACT_WRITE,
        ACT_REJECT
    } sbm_act_e;
endpackage

// File: rtl/sbm_bank.sv
module sbm_bank
    import sbm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ROW_W  = 4,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  sbm_op_e           acc_op,
    input  logic [ROW_W-1:0]  acc_row,
    input  logic [DATA_W-1:0] acc_data,
    input  logic              acc_ptr,
    input  logic              acc_pre,
    input  logic              acc_post,
    input  logic [TAG_W-1:0]  acc_tag,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_ptr,
    output logic              res_ok,
    output logic [TAG_W-1:0]  res_tag
);
    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] word_q [DEPTH];
    logic [DEPTH-1:0]  flag_q;
    logic [DEPTH-1:0]  ptr_q;

    sbm_act_e act;
    logic     flag_now;
    logic     flag_set;

    assign flag_now = flag_q[acc_row];

    // flag test and decision happen in the same cycle as the update
    always_comb begin
        act      = ACT_IDLE;
        flag_set = 1'b0;
        if (acc_valid) begin
            unique case (acc_op)
                OP_LOAD:   act = ACT_READ;
                OP_STORE:  act = ACT_WRITE;
                OP_SLOAD: begin
                    act      = (flag_now == acc_pre) ? ACT_READ : ACT_REJECT;
                    flag_set = (flag_now == acc_pre);
                end
                OP_SSTORE: begin
                    act      = (flag_now == acc_pre) ? ACT_WRITE : ACT_REJECT;
                    flag_set = (flag_now == acc_pre);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (act == ACT_WRITE) begin
            word_q[acc_row] <= acc_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            ptr_q  <= '0;
        end else begin
            if (act == ACT_WRITE) begin
                ptr_q[acc_row] <= acc_ptr;
            end
            if (flag_set) begin
                flag_q[acc_row] <= acc_post;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_ptr   <= 1'b0;
            res_ok    <= 1'b0;
            res_tag   <= '0;
        end else begin
            res_valid <= (act != ACT_IDLE);
            res_tag   <= acc_tag;
            unique case (act)
                ACT_READ: begin
                    res_data <= word_q[acc_row];
                    res_ptr  <= ptr_q[acc_row];
                    res_ok   <= 1'b1;
                end
                ACT_WRITE: begin
                    res_data <= '0;
                    res_ptr  <= 1'b0;
                    res_ok   <= 1'b1;
                end
                ACT_REJECT, ACT_IDLE: begin
                    res_data <= '0;
                    res_ptr  <= 1'b0;
                    res_ok   <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/sbm_rsp_merge.sv
module sbm_rsp_merge #(
    parameter int NB     = 2,
    parameter int DATA_W = 64,
    parameter int TAG_W  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NB-1:0]                in_valid,
    input  logic [NB-1:0][DATA_W-1:0]    in_data,
    input  logic [NB-1:0]                in_ptr,
    input  logic [NB-1:0]                in_ok,
    input  logic [NB-1:0][TAG_W-1:0]     in_tag,
    output logic                         out_valid,
    output logic [DATA_W-1:0]            out_data,
    output logic                         out_ptr,
    output logic                         out_ok,
    output logic [TAG_W-1:0]             out_tag
);
    logic [DATA_W-1:0] sel_data;
    logic              sel_ptr;
    logic              sel_ok;
    logic [TAG_W-1:0]  sel_tag;

    // at most one bank answers per cycle: OR of the gated results
    always_comb begin
        sel_data = '0;
        sel_ptr  = 1'b0;
        sel_ok   = 1'b0;
        sel_tag  = '0;
        for (int b = 0; b < NB; b++) begin
            if (in_valid[b]) begin
                sel_data = sel_data | in_data[b];
                sel_ptr  = sel_ptr  | in_ptr[b];
                sel_ok   = sel_ok   | in_ok[b];
                sel_tag  = sel_tag  | in_tag[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ptr   <= 1'b0;
            out_ok    <= 1'b0;
            out_tag   <= '0;
        end else begin
            out_valid <= |in_valid;
            out_data  <= sel_data;
            out_ptr   <= sel_ptr;
            out_ok    <= sel_ok;
            out_tag   <= sel_tag;
        end
    end
endmodule

// File: rtl/syncbit_mem.sv
module syncbit_mem
    import sbm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 5,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_ptr,
    input  logic              req_pre,
    input  logic              req_post,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_ptr,
    output logic              rsp_ok,
    output logic [TAG_W-1:0]  rsp_tag
);
    localparam int NB    = 2;
    localparam int ROW_W = ADDR_W - 1;

    // stage 1: capture the request
    logic              s1_valid;
    sbm_op_e           s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [DATA_W-1:0] s1_data;
    logic              s1_ptr;
    logic              s1_pre;
    logic              s1_post;
    logic [TAG_W-1:0]  s1_tag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= OP_LOAD;
            s1_addr  <= '0;
            s1_data  <= '0;
            s1_ptr   <= 1'b0;
            s1_pre   <= 1'b0;
            s1_post  <= 1'b0;
            s1_tag   <= '0;
        end else begin
            s1_valid <= req_valid;
            s1_op    <= sbm_op_e'(req_op);
            s1_addr  <= req_addr;
            s1_data  <= req_data;
            s1_ptr   <= req_ptr;
            s1_pre   <= req_pre;
            s1_post  <= req_post;
            s1_tag   <= req_tag;
        end
    end

    // stage 2: word-interleaved banks
    logic [NB-1:0]              b_valid;
    logic [NB-1:0][DATA_W-1:0]  b_data;
    logic [NB-1:0]              b_ptr;
    logic [NB-1:0]              b_ok;
    logic [NB-1:0][TAG_W-1:0]   b_tag;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        sbm_bank #(
            .DATA_W (DATA_W),
            .ROW_W  (ROW_W),
            .TAG_W  (TAG_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_valid (s1_valid && (s1_addr[0] == 1'(g))),
            .acc_op    (s1_op),
            .acc_row   (s1_addr[ADDR_W-1:1]),
            .acc_data  (s1_data),
            .acc_ptr   (s1_ptr),
            .acc_pre   (s1_pre),
            .acc_post  (s1_post),
            .acc_tag   (s1_tag),
            .res_valid (b_valid[g]),
            .res_data  (b_data[g]),
            .res_ptr   (b_ptr[g]),
            .res_ok    (b_ok[g]),
            .res_tag   (b_tag[g])
        );
    end

    // stage 3: response register
    sbm_rsp_merge #(
        .NB     (NB),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (b_valid),
        .in_data   (b_data),
        .in_ptr    (b_ptr),
        .in_ok     (b_ok),
        .in_tag    (b_tag),
        .out_valid (rsp_valid),
        .out_data  (rsp_data),
        .out_ptr   (rsp_ptr),
        .out_ok    (rsp_ok),
        .out_tag   (rsp_tag)
    );
endmodule

// File: rtl/syncbit_mem_chk.sv
module syncbit_mem_chk #(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [TAG_W-1:0]  req_tag,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_ptr,
    input logic              rsp_ok,
    input logic [TAG_W-1:0]  rsp_tag
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    always @(posedge clk) begin
        if (!rst_n) AST_QUIET_IN_RESET: assert (!rsp_valid); // R1
    end

    AST_LATENCY_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (rsp_valid == $past(req_valid, 3))); // R6

    AST_TAG_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && rsp_valid) |-> (rsp_tag == $past(req_tag, 3))); // R10

    AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (rsp_data == '0 && !rsp_ptr)); // R5

    AST_PLAIN_SUCCEEDS: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && rsp_valid && !$past(req_op[1], 3)) |-> rsp_ok); // R2

    AST_STORE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && rsp_valid && $past(req_op[0], 3)) |-> (rsp_data == '0)); // R4
endmodule

bind syncbit_mem syncbit_mem_chk #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_tag   (req_tag),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_ptr   (rsp_ptr),
    .rsp_ok    (rsp_ok),
    .rsp_tag   (rsp_tag)
);

// File: tb/sim_syncbit_mem.sv
`timescale 1ns/1ps
module sim_syncbit_mem;
    localparam int DW = 64;
    localparam int AW = 5;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic req_ptr = 1'b0, req_pre = 1'b0, req_post = 1'b0;
    logic [TW-1:0] req_tag = '0;
    logic rsp_valid, rsp_ptr, rsp_ok;
    logic [DW-1:0] rsp_data;
    logic [TW-1:0] rsp_tag;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    syncbit_mem #(.DATA_W(DW), .ADDR_W(AW), .TAG_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_ptr(req_ptr),
        .req_pre(req_pre), .req_post(req_post), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ptr(rsp_ptr),
        .rsp_ok(rsp_ok), .rsp_tag(rsp_tag)
    );

    // independent model of the storage
    logic [DW-1:0] m_data [1<<AW];
    bit m_flag [1<<AW];
    bit m_ptr  [1<<AW];

    // expected responses in flight
    bit pv [3];
    logic [DW-1:0] pd [3];
    bit pp [3], pok [3];
    logic [TW-1:0] pt [3];
    int pr [3];

    task automatic check_out();
        if (pv[2] || rsp_valid) begin
            checks++;
            if (rsp_valid !== pv[2]) begin
                fails++;
                $display("FAIL R%0d valid: actual %b expected %b", pr[2], rsp_valid, pv[2]);
            end else if (rsp_data !== pd[2] || rsp_ptr !== pp[2] || rsp_ok !== pok[2] || rsp_tag !== pt[2]) begin
                fails++;
                $display("FAIL R%0d rsp: actual d=%h p=%b ok=%b t=%h expected d=%h p=%b ok=%b t=%h",
                         pr[2], rsp_data, rsp_ptr, rsp_ok, rsp_tag, pd[2], pp[2], pok[2], pt[2]);
            end
        end
    endtask

    // one cycle: check the due response, then issue a request (or idle)
    task automatic step(input bit v, input int op, input int a, input logic [DW-1:0] d,
                        input bit p, input bit pre, input bit post, input int tag, input int rq);
        bit ev, ep, eok;
        logic [DW-1:0] ed;
        @(negedge clk);
        check_out();
        for (int i = 2; i > 0; i--) begin
            pv[i] = pv[i-1]; pd[i] = pd[i-1]; pp[i] = pp[i-1];
            pok[i] = pok[i-1]; pt[i] = pt[i-1]; pr[i] = pr[i-1];
        end
        ev = v; ed = '0; ep = 1'b0; eok = 1'b0;
        if (v) begin
            case (op)
                0: begin ed = m_data[a]; ep = m_ptr[a]; eok = 1'b1; end
                1: begin m_data[a] = d; m_ptr[a] = p; eok = 1'b1; end
                2: if (m_flag[a] == pre) begin
                       ed = m_data[a]; ep = m_ptr[a]; eok = 1'b1; m_flag[a] = post;
                   end
                default: if (m_flag[a] == pre) begin
                       m_data[a] = d; m_ptr[a] = p; eok = 1'b1; m_flag[a] = post;
                   end
            endcase
        end
        pv[0] = ev; pd[0] = ed; pp[0] = ep; pok[0] = eok; pt[0] = TW'(tag); pr[0] = rq;
        req_valid = v; req_op = 2'(op); req_addr = AW'(a); req_data = d;
        req_ptr = p; req_pre = pre; req_post = post; req_tag = TW'(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, '0, 1'b0, 1'b0, 1'b0, 0, 6);
    endtask

    // R1: quiet during reset, flags and pointers clear afterwards
    task automatic t_reset();
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 valid in reset: actual %b expected 0", rsp_valid);
        end
        rst_n = 1'b1;
        step(1'b1, 2, 6, '0, 1'b0, 1'b1, 1'b0, 3, 1); // R1 fresh flag is 0
        step(1'b1, 3, 7, 64'h77, 1'b1, 1'b1, 1'b0, 4, 1); // R1 rejected store
        idle(4);
    endtask

    // R2: plain store and load with pointer bit
    task automatic t_plain();
        step(1'b1, 1, 4, 64'hA5A5_0000_1234_5678, 1'b1, 1'b0, 1'b0, 1, 2);
        step(1'b1, 1, 5, 64'h0F0F_F0F0_0000_FFFF, 1'b0, 1'b0, 1'b0, 2, 2);
        step(1'b1, 0, 4, '0, 1'b0, 1'b0, 1'b0, 3, 2);
        step(1'b1, 0, 5, '0, 1'b0, 1'b0, 1'b0, 4, 2);
        step(1'b1, 0, 7, '0, 1'b0, 1'b0, 1'b0, 5, 5); // R5 word 7 untouched: pointer stays 0
        idle(4);
    endtask

    // R3 R4 R5: conditional success and refusal
    task automatic t_cond();
        step(1'b1, 3, 6, 64'hBEEF, 1'b1, 1'b0, 1'b1, 6, 4);  // R4
        step(1'b1, 3, 6, 64'hDEAD, 1'b0, 1'b0, 1'b1, 7, 5);  // R5 refused
        step(1'b1, 0, 6, '0, 1'b0, 1'b0, 1'b0, 8, 5);        // R5 data kept
        step(1'b1, 2, 6, '0, 1'b0, 1'b1, 1'b0, 9, 3);        // R3
        step(1'b1, 2, 6, '0, 1'b0, 1'b1, 1'b0, 10, 5);       // R5 flag was cleared
        idle(4);
    endtask

    // R7: plain accesses leave the flag alone
    task automatic t_preserve();
        step(1'b1, 3, 8, 64'h1111, 1'b0, 1'b0, 1'b1, 11, 7);
        step(1'b1, 1, 8, 64'h2222, 1'b1, 1'b0, 1'b0, 12, 7);
        step(1'b1, 0, 8, '0, 1'b0, 1'b0, 1'b0, 13, 7);
        step(1'b1, 2, 8, '0, 1'b0, 1'b1, 1'b1, 14, 7);        // R7 flag still 1
        idle(4);
    endtask

    // R8: back-to-back conditional traffic on one word
    task automatic t_b2b();
        step(1'b1, 3, 10, 64'hC0DE_0001, 1'b1, 1'b0, 1'b1, 1, 8);
        step(1'b1, 2, 10, '0, 1'b0, 1'b1, 1'b0, 2, 8);
        step(1'b1, 2, 10, '0, 1'b0, 1'b1, 1'b0, 3, 8);
        step(1'b1, 3, 10, 64'hC0DE_0002, 1'b0, 1'b0, 1'b1, 4, 8);
        step(1'b1, 3, 10, 64'hC0DE_0003, 1'b1, 1'b0, 1'b1, 5, 8);
        step(1'b1, 0, 10, '0, 1'b0, 1'b0, 1'b0, 6, 8);
        idle(4);
    endtask

    // R6 R9 R10: streaming across both banks, neighbour independence
    task automatic t_stream();
        for (int i = 16; i < 24; i++)
            step(1'b1, 1, i, 64'h5000 + 64'(i * 3), 1'(i), 1'b0, 1'b0, i - 16, 6);
        for (int i = 23; i >= 16; i--)
            step(1'b1, 0, i, '0, 1'b0, 1'b0, 1'b0, i - 8, 10);
        step(1'b1, 3, 12, 64'h99, 1'b0, 1'b0, 1'b1, 2, 9);
        step(1'b1, 2, 13, '0, 1'b0, 1'b1, 1'b0, 3, 9);          // R9 neighbour flag still 0
        step(1'b1, 0, 13, '0, 1'b0, 1'b0, 1'b0, 4, 9);
        step(1'b1, 2, 12, '0, 1'b0, 1'b1, 1'b0, 5, 9);
        idle(5);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) begin m_flag[i] = 1'b0; m_ptr[i] = 1'b0; end
        for (int i = 0; i < 3; i++) begin
            pv[i] = 1'b0; pd[i] = '0; pp[i] = 1'b0; pok[i] = 1'b0; pt[i] = '0; pr[i] = 6;
        end
        m_data[13] = 64'h0; // written before any read below
        t_reset();
        step(1'b1, 1, 13, 64'h0, 1'b0, 1'b0, 1'b0, 0, 2);
        t_plain();
        t_cond();
        t_preserve();
        t_b2b();
        t_stream();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R6 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule